// File: doc/BRIEF.md
# Six-Source Interrupt Aggregator

This block gathers interrupt requests from six peripheral sources and presents them to the CPU as a single level-sensitive interrupt line. Each source owns one bit of a pending register. A one-cycle request pulse from the source sets its bit, and the bit then stays set until that source's own clear strobe arrives. The clear strobes come from decode logic in the peripherals, which is not part of this block. Each peripheral has its own clearing action:

- the video source clears when its current-line register is written;
- the display-processor source clears when bit 11 of its mode register is written;
- the parallel-interface source clears when a 1 is written to bit 1 of its status register;
- the audio source clears on any write to its status register.

Software can read the pending register but has no path to write it.

A six-bit enable mask selects which pending bits may reach the CPU. Software changes the mask with one write word that holds a clear/set pair for every source, so no read-modify-write is needed. The interrupt output is a registered OR of the pending bits ANDed with the mask.

Top module: `irq_gather`

## Requirements
- R1: During reset (`rst_n` low) the pending register, the mask and `cpu_irq_o` are all zero.
- R2: A 1 on `req_i[i]` sets pending bit i at that clock edge. The bit stays set while no clear strobe arrives for it. Bit positions from 5 down to 0 are: display processor, parallel interface, video, audio, serial, signal processor.
- R3: A 1 on `clr_i[i]` with `req_i[i]` low clears pending bit i at that clock edge. Other pending bits are untouched.
- R4: When `req_i[i]` and `clr_i[i]` are both 1 in the same cycle, pending bit i ends up set.
- R5: On a cycle with `mask_we` high, `mask_wdata[2i+1]`=1 with `mask_wdata[2i]`=0 sets mask bit i. `mask_wdata[2i]`=1 with `mask_wdata[2i+1]`=0 clears mask bit i.
- R6: A mask bit is unchanged when its pair is written as 00 or 11, and when `mask_we` is low. Bits 31:12 of `mask_wdata` have no effect.
- R7: `pend_o` is a 32-bit word that carries the pending bits in 5:0 and zeros in 31:6. The mask write port never changes it.
- R8: `cpu_irq_o` is 1 one clock after any cycle in which some pending bit and its mask bit are both 1, and 0 one clock after any cycle in which none is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 6 | Per-source request pulses |
| clr_i | input | 6 | Per-source clear strobes from peripheral register writes |
| mask_we | input | 1 | Mask write enable |
| mask_wdata | input | 32 | Mask write word: bit 2i is the clear for source i, bit 2i+1 is its set |
| pend_o | output | 32 | Read-only pending word |
| mask_o | output | 6 | Current enable mask |
| cpu_irq_o | output | 1 | Registered interrupt line to the CPU |

## Verification
The assertions take for granted that every input is a known 0 or 1 at each rising edge. They also take for granted that requests, clears and mask writes are sampled only at that edge.

The bench keeps within this by driving all inputs just after the falling edge and holding them steady through the next rising edge. It samples outputs at the following falling edge. It deliberately includes same-cycle request and clear on the same bit, 11 pairs, and write words with garbage in the unused upper bits, because those are the cases where set-wins and pair decoding matter.

// File: rtl/irq_gather.sv
module irq_gather #(
  parameter int NSRC = 6,
  parameter int WORD = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic            mask_we,
  input  logic [WORD-1:0] mask_wdata,
  output logic [WORD-1:0] pend_o,
  output logic [NSRC-1:0] mask_o,
  output logic            cpu_irq_o
);

  localparam int PAIRW = 2 * NSRC;

  logic [NSRC-1:0] pend_q, pend_nxt;
  logic [NSRC-1:0] mask_q, mask_nxt;
  logic            irq_q;
  logic            unused_hi;

  assign unused_hi = ^mask_wdata[WORD-1:PAIRW];

  // set wins over clear
  assign pend_nxt = (pend_q & ~clr_i) | req_i;

  for (genvar i = 0; i < NSRC; i++) begin : g_pair
    logic do_clr, do_set;
    assign do_clr = mask_we &  mask_wdata[2*i] & ~mask_wdata[2*i+1];
    assign do_set = mask_we & ~mask_wdata[2*i] &  mask_wdata[2*i+1];
    assign mask_nxt[i] = do_set | (mask_q[i] & ~do_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_nxt;
      mask_q <= mask_nxt;
      irq_q  <= |(pend_q & mask_q);
    end
  end

  assign pend_o    = {{(WORD-NSRC){1'b0}}, pend_q};
  assign mask_o    = mask_q;
  assign cpu_irq_o = irq_q;

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_o[NSRC-1:0] & $past(req_i)) == $past(req_i)));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pend_o[NSRC-1:0] ^ $past(pend_o[NSRC-1:0])) & ~$past(req_i | clr_i)) == '0));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_o[NSRC-1:0] & $past(clr_i & ~req_i)) == '0));

  p_mask_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_o));

  p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pend_o[WORD-1:NSRC] == '0);

  p_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cpu_irq_o == |($past(pend_o[NSRC-1:0]) & $past(mask_o))));

endmodule

// File: tb/tb_irq_gather.sv
module tb_irq_gather;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  req_i = '0;
  logic [5:0]  clr_i = '0;
  logic        mask_we = 1'b0;
  logic [31:0] mask_wdata = '0;
  logic [31:0] pend_o;
  logic [5:0]  mask_o;
  logic        cpu_irq_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_gather dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .clr_i(clr_i),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .pend_o(pend_o), .mask_o(mask_o), .cpu_irq_o(cpu_irq_o)
  );

  localparam int NV = 13;
  localparam logic [5:0]  T_REQ [NV] = '{6'h01, 6'h00, 6'h00, 6'h00, 6'h24, 6'h00, 6'h01,
                                         6'h00, 6'h00, 6'h3F, 6'h00, 6'h00, 6'h00};
  localparam logic [5:0]  T_CLR [NV] = '{6'h00, 6'h00, 6'h00, 6'h01, 6'h00, 6'h00, 6'h21,
                                         6'h00, 6'h00, 6'h3F, 6'h00, 6'h3F, 6'h00};
  localparam logic        T_WE  [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0,
                                         1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam logic [31:0] T_WD  [NV] = '{32'h0, 32'h2, 32'h0, 32'h0, 32'h0, 32'h803, 32'h0,
                                         32'h555, 32'hFFF, 32'h0, 32'hFFFFFAAA, 32'h0, 32'h0};
  localparam logic [5:0]  T_PND [NV] = '{6'h01, 6'h01, 6'h01, 6'h00, 6'h24, 6'h24, 6'h05,
                                         6'h05, 6'h05, 6'h3F, 6'h3F, 6'h00, 6'h00};
  localparam logic [5:0]  T_MSK [NV] = '{6'h00, 6'h01, 6'h01, 6'h01, 6'h01, 6'h21, 6'h21,
                                         6'h00, 6'h00, 6'h00, 6'h3F, 6'h3F, 6'h3F};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] rq, input logic [5:0] cl,
                       input logic we, input logic [31:0] wd);
    req_i = rq; clr_i = cl; mask_we = we; mask_wdata = wd;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [5:0] prev_p, prev_m;
    repeat (3) @(negedge clk);
    chk("R1 reset pend", pend_o, 32'h0);
    chk("R1 reset mask", {26'h0, mask_o}, 32'h0);
    chk("R1 reset irq", {31'h0, cpu_irq_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // table: R2 R3 R4 R5 R6 R7 R8
    prev_p = '0; prev_m = '0;
    for (int k = 0; k < NV; k++) begin
      drive(T_REQ[k], T_CLR[k], T_WE[k], T_WD[k]);
      chk($sformatf("R2/R3/R4/R7 step %0d pend", k), pend_o, {26'h0, T_PND[k]});
      chk($sformatf("R5/R6 step %0d mask", k), {26'h0, mask_o}, {26'h0, T_MSK[k]});
      chk($sformatf("R8 step %0d irq", k), {31'h0, cpu_irq_o}, {31'h0, |(prev_p & prev_m)});
      prev_p = T_PND[k]; prev_m = T_MSK[k];
    end
    drive('0, '0, 1'b0, '0);

    // R2 R3 per-bit walk, R8 per source with full mask
    for (int i = 0; i < 6; i++) begin
      drive(6'(1 << i), '0, 1'b0, '0);
      chk($sformatf("R2 walk bit %0d set", i), pend_o, 32'(1 << i));
      chk($sformatf("R8 walk bit %0d irq low", i), {31'h0, cpu_irq_o}, 32'h0);
      drive('0, '0, 1'b0, '0);
      chk($sformatf("R8 walk bit %0d irq high", i), {31'h0, cpu_irq_o}, 32'h1);
      drive('0, 6'(1 << i), 1'b0, '0);
      chk($sformatf("R3 walk bit %0d clear", i), pend_o, 32'h0);
      drive('0, '0, 1'b0, '0);
      chk($sformatf("R8 walk bit %0d irq drop", i), {31'h0, cpu_irq_o}, 32'h0);
    end

    // R7: mask write of all ones leaves pend untouched
    drive('0, '0, 1'b1, 32'hFFFFFFFF);
    chk("R7 mask write no pend effect", pend_o, 32'h0);
    chk("R6 pair 11 keeps mask", {26'h0, mask_o}, 32'h3F);

    // R9-style masked: pend with mask cleared keeps irq low (R8)
    drive(6'h12, '0, 1'b1, 32'h555);
    drive('0, '0, 1'b0, '0);
    drive('0, '0, 1'b0, '0);
    chk("R8 masked pending no irq", {31'h0, cpu_irq_o}, 32'h0);
    chk("R2 held pending", pend_o, 32'h12);

    // R1: reset mid-run
    drive(6'h3F, '0, 1'b1, 32'hAAA);
    drive('0, '0, 1'b0, '0);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid reset pend", pend_o, 32'h0);
    chk("R1 mid reset mask", {26'h0, mask_o}, 32'h0);
    chk("R1 mid reset irq", {31'h0, cpu_irq_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule